// File: doc/BRIEF.md
# Cascaded Sink-Driver Chain Loader

This block runs on the system clock and loads a daisy chain of `NUM_DEV` latched sink drivers, each holding `DEV_BITS` bits. A host hands over one whole frame on a valid/ready handshake. The block then produces the shift clock, the serial data, the latch strobe and the blanking line for the chain. Every interval between those edges is a cycle count set by a parameter. Each count is the ceiling of the required minimum time divided by the system clock period, so the drivers' setup, hold, pulse-width and strobe rules are met by construction.

The block runs in one of two modes, chosen per frame when the frame is accepted. In strobed mode the chain's latches stay closed while the bits move. After the last clock a single strobe pulse moves all the bits to the outputs at once, and the blanking line stays low. In transparent mode the latches are held open for the whole load, so the strobe line is high throughout. The blanking line is driven high over the same window, so that bits passing through never show on the outputs. In both modes a one-cycle done pulse follows the end of the strobe. A new frame can be accepted in that same cycle.

Top module: `chain_loader`

## Requirements
- R1: After reset, `frame_ready_o` is 1 and `sck_o`, `sdo_o`, `strobe_o`, `blank_o` and `done_o` are all 0.
- R2: A frame is taken only when `frame_valid_i` and `frame_ready_o` are both 1 at a clock edge. `frame_ready_o` is 0 from the following cycle until the done cycle. Data and valid presented while busy have no effect on what is shifted.
- R3: Each frame produces exactly `NUM_DEV*DEV_BITS` rising edges on `sck_o`, and bit `FRAME_W-1` is sent first, moving down to bit 0. Device k counts from the host end (k=0 nearest). After the load, device k holds frame bits `[k*DEV_BITS+DEV_BITS-1 : k*DEV_BITS]`.
- R4: `sdo_o` holds its value for at least `SETUP_CYC` cycles before every rising edge of `sck_o`. For the first bit this is exactly `SETUP_CYC` cycles after acceptance.
- R5: `sck_o` stays high for exactly `HIGH_CYC` cycles. `sdo_o` does not change while `sck_o` is high, nor within `LOW_CYC` cycles after its fall.
- R6: Between two rising edges of one frame, `sck_o` is low for exactly `LOW_CYC+SETUP_CYC` cycles.
- R7: In strobed mode `strobe_o` stays low while bits are shifted. It rises exactly `LOW_CYC+GAP_CYC` cycles after the last fall of `sck_o` and stays high for exactly `STROBE_CYC` cycles.
- R8: `done_o` is a one-cycle pulse issued one cycle after `strobe_o` falls. `frame_ready_o` is 1 in that cycle, so a frame presented then is accepted at once.
- R9: With `blank_mode_i`=1 at acceptance, `strobe_o` and `blank_o` both rise in the cycle after acceptance and both fall when the strobe interval ends. `sck_o` is never high while either is low. In strobed mode `blank_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | NUM_DEV*DEV_BITS | Frame to load; top bits belong to the farthest device |
| frame_valid_i | input | 1 | Frame offered |
| frame_ready_o | output | 1 | Block idle and able to take a frame |
| blank_mode_i | input | 1 | 1 selects transparent mode for the offered frame |
| sck_o | output | 1 | Shift clock to the chain |
| sdo_o | output | 1 | Serial data to the chain |
| strobe_o | output | 1 | Latch strobe to the chain |
| blank_o | output | 1 | Output blanking (high turns chain outputs off) |
| done_o | output | 1 | One-cycle pulse after the strobe ends |

## Verification
Two things can fall in one cycle: the done pulse that closes one frame and the handshake that opens the next. The bench provokes this by raising valid with new data in the done cycle itself. It then checks that the block leaves ready at once and that the following load has correct timing and bit order, across changes of mode between the two frames. A bench model of the shift chain and its latches gives the bits each device ends up with. Monitors sampled on the falling edge measure every clock, data and strobe interval against the parameter values.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_LAT_WAIT,
    ST_LAT_PULSE,
    ST_DONE
  } ld_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cl_interval_timer.sv
// Down-counter measuring how long the sequencer stays in a phase.
module cl_interval_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/cl_bit_serializer.sv
// Parallel-in, serial-out register; most significant bit leaves first.
module cl_bit_serializer #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] data_i,
  input  logic          shift_i,
  output logic          sdo_o,
  output logic          last_o
);
  localparam int LEFT_W = $clog2(FW + 1);

  logic [FW-1:0]     sh;
  logic [LEFT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load_i) begin
      sh   <= data_i;
      left <= LEFT_W'(FW);
    end else if (shift_i) begin
      sh   <= {sh[FW-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign sdo_o  = sh[FW-1];
  assign last_o = (left == LEFT_W'(1));
endmodule

// File: rtl/cl_sequencer.sv
// Phase sequencer: decides each phase and registers the chain-side lines.
module cl_sequencer
  import chain_loader_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int SETUP_CYC  = 2,
  parameter int HIGH_CYC   = 2,
  parameter int LOW_CYC    = 2,
  parameter int GAP_CYC    = 2,
  parameter int STROBE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             mode_i,
  input  logic             tmr_zero_i,
  input  logic             last_bit_i,
  output logic             ready_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             shift_o,
  output logic             sck_o,
  output logic             strobe_o,
  output logic             blank_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] SU_V  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LP_V  = CNT_W'(STROBE_CYC - 1);

  ld_state_t state, state_n;
  logic      mode_q, mode_n, busy_n;
  logic      sck_q, strobe_q, blank_q, done_q;

  always_comb begin
    state_n = state;
    shift_o = 1'b0;
    unique case (state)
      ST_IDLE:      if (accept_i)   state_n = ST_SETUP;
      ST_SETUP:     if (tmr_zero_i) state_n = ST_CLK_HI;
      ST_CLK_HI:    if (tmr_zero_i) state_n = ST_CLK_LO;
      ST_CLK_LO: begin
        if (tmr_zero_i) begin
          if (last_bit_i) begin
            state_n = ST_LAT_WAIT;
          end else begin
            state_n = ST_SETUP;
            shift_o = 1'b1;
          end
        end
      end
      ST_LAT_WAIT:  if (tmr_zero_i) state_n = ST_LAT_PULSE;
      ST_LAT_PULSE: if (tmr_zero_i) state_n = ST_DONE;
      ST_DONE:      state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  // Phase length loaded on every change of phase.
  always_comb begin
    tmr_load_o = (state_n != state);
    unique case (state_n)
      ST_SETUP:     tmr_val_o = SU_V;
      ST_CLK_HI:    tmr_val_o = HI_V;
      ST_CLK_LO:    tmr_val_o = LO_V;
      ST_LAT_WAIT:  tmr_val_o = GAP_V;
      ST_LAT_PULSE: tmr_val_o = LP_V;
      default:      tmr_val_o = '0;
    endcase
  end

  assign mode_n = accept_i ? mode_i : mode_q;
  assign busy_n = (state_n != ST_IDLE) && (state_n != ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      sck_q    <= 1'b0;
      strobe_q <= 1'b0;
      blank_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state    <= state_n;
      mode_q   <= mode_n;
      sck_q    <= (state_n == ST_CLK_HI);
      strobe_q <= (state_n == ST_LAT_PULSE) || (mode_n && busy_n);
      blank_q  <= mode_n && busy_n;
      done_q   <= (state == ST_DONE);
    end
  end

  assign ready_o  = (state == ST_IDLE);
  assign sck_o    = sck_q;
  assign strobe_o = strobe_q;
  assign blank_o  = blank_q;
  assign done_o   = done_q;
endmodule

// File: rtl/chain_loader.sv
// Loads a cascaded chain of latched sink drivers from the system clock.
module chain_loader
  import chain_loader_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int DEV_BITS   = 8,
  parameter int SETUP_CYC  = 13,
  parameter int HIGH_CYC   = 13,
  parameter int LOW_CYC    = 13,
  parameter int GAP_CYC    = 25,
  parameter int STROBE_CYC = 25,
  localparam int FRAME_W   = NUM_DEV * DEV_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               frame_valid_i,
  output logic               frame_ready_o,
  input  logic               blank_mode_i,
  output logic               sck_o,
  output logic               sdo_o,
  output logic               strobe_o,
  output logic               blank_o,
  output logic               done_o
);
  localparam int MAX_CYC = imax(imax(imax(SETUP_CYC, HIGH_CYC), imax(LOW_CYC, GAP_CYC)), STROBE_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, ready, tmr_load, tmr_zero, shift, last_bit;
  logic [CNT_W-1:0] tmr_val;

  assign accept        = frame_valid_i && ready;
  assign frame_ready_o = ready;

  cl_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  cl_bit_serializer #(.FW(FRAME_W)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .data_i (frame_i),
    .shift_i(shift),
    .sdo_o  (sdo_o),
    .last_o (last_bit)
  );

  cl_sequencer #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW_CYC   (LOW_CYC),
    .GAP_CYC   (GAP_CYC),
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .mode_i    (blank_mode_i),
    .tmr_zero_i(tmr_zero),
    .last_bit_i(last_bit),
    .ready_o   (ready),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .shift_o   (shift),
    .sck_o     (sck_o),
    .strobe_o  (strobe_o),
    .blank_o   (blank_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/chain_loader_chk.sv
module chain_loader_chk (
  input logic clk,
  input logic rst,
  input logic frame_valid_i,
  input logic frame_ready_o,
  input logic sck_o,
  input logic sdo_o,
  input logic strobe_o,
  input logic blank_o,
  input logic done_o
);
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    frame_valid_i && frame_ready_o |=> !frame_ready_o);

  p_no_clock_idle_r2: assert property (@(posedge clk) disable iff (rst)
    frame_ready_o |-> !sck_o);

  p_data_at_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $stable(sdo_o));

  p_data_while_high_r5: assert property (@(posedge clk) disable iff (rst)
    sck_o && $past(sck_o) |-> $stable(sdo_o));

  p_strobe_no_clock_r7: assert property (@(posedge clk) disable iff (rst)
    strobe_o && !blank_o |-> !sck_o);

  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_o) |=> done_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_blank_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> strobe_o);
endmodule

bind chain_loader chain_loader_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_valid_i(frame_valid_i),
  .frame_ready_o(frame_ready_o),
  .sck_o        (sck_o),
  .sdo_o        (sdo_o),
  .strobe_o     (strobe_o),
  .blank_o      (blank_o),
  .done_o       (done_o)
);

// File: tb/tb_chain_loader.sv
module tb_chain_loader;
  localparam int ND = 2, DB = 8, FW = ND * DB;
  localparam int SU = 2, HI = 2, LO = 3, GP = 3, LP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [FW-1:0] frame_i = '0;
  logic          frame_valid_i = 1'b0, blank_mode_i = 1'b0;
  logic          frame_ready_o, sck_o, sdo_o, strobe_o, blank_o, done_o;

  always #2 clk = ~clk;

  chain_loader #(.NUM_DEV(ND), .DEV_BITS(DB), .SETUP_CYC(SU), .HIGH_CYC(HI),
                 .LOW_CYC(LO), .GAP_CYC(GP), .STROBE_CYC(LP)) dut (
    .clk(clk), .rst(rst), .frame_i(frame_i), .frame_valid_i(frame_valid_i),
    .frame_ready_o(frame_ready_o), .blank_mode_i(blank_mode_i), .sck_o(sck_o),
    .sdo_o(sdo_o), .strobe_o(strobe_o), .blank_o(blank_o), .done_o(done_o));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Model of the cascaded shift chain and its latches.
  logic [FW-1:0] chain = '0, latched = '0;
  always @(posedge sck_o) chain <= {chain[FW-2:0], sdo_o};

  // Interval monitors, sampled on the falling clock edge.
  int  f_rises, v_setup, v_hold, v_high, v_low, v_mode, gap, swidth, dage;
  int  hi_run = 0, sfall = 1000, stab = 0, srun = 0, fage = 0;
  bit  mode_rec = 0;
  logic p_sck = 0, p_sdo = 0, p_str = 0, p_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (strobe_o) latched = chain;
      if (sck_o && !p_sck) begin
        if (stab < SU) v_setup++;
        if (f_rises > 0 && sfall != LO + SU) v_low++;
        hi_run = 1;
        f_rises++;
      end else if (sck_o) hi_run++;
      if (!sck_o && p_sck) begin
        if (hi_run != HI) v_high++;
        sfall = 1;
      end else if (!sck_o && sfall < 100000) sfall++;
      if (sdo_o != p_sdo) begin
        if (sck_o || sfall <= LO) v_hold++;
        stab = 1;
      end else stab++;
      if (strobe_o && !p_str) begin gap = sfall - 1; srun = 1; end
      else if (strobe_o) srun++;
      if (!strobe_o && p_str) begin swidth = srun; fage = 0; end
      else fage++;
      if (done_o && !p_done) dage = fage;
      if (mode_rec) begin
        if (sck_o && !(strobe_o && blank_o)) v_mode++;
      end else begin
        if (blank_o) v_mode++;
        if (sck_o && strobe_o) v_mode++;
      end
      p_sck = sck_o; p_sdo = sdo_o; p_str = strobe_o; p_done = done_o;
    end
  end

  // pre: valid already raised in the done cycle of the previous frame.
  // next_arm: raise valid with next data in this frame's done cycle.
  task automatic run_frame(input logic [FW-1:0] d, input bit byp, input bit pre,
                           input bit noise, input bit next_arm,
                           input logic [FW-1:0] nd, input bit nbyp);
    if (!pre) begin
      frame_i = d; blank_mode_i = byp; frame_valid_i = 1'b1;
      do @(negedge clk); while (!frame_ready_o);
    end
    @(posedge clk); #1;
    f_rises = 0; v_setup = 0; v_hold = 0; v_high = 0; v_low = 0; v_mode = 0;
    gap = -1; swidth = -1; dage = -1; mode_rec = byp;
    chk(frame_ready_o == 1'b0, "R2 ready drops after take", frame_ready_o, 0);
    if (noise) begin
      frame_i = ~d; blank_mode_i = ~byp;
      repeat (5) @(posedge clk);
      #1 chk(frame_ready_o == 1'b0, "R2 ready stays low while busy", frame_ready_o, 0);
    end
    frame_valid_i = 1'b0;
    do @(negedge clk); while (!done_o);
    #1;
    chk(f_rises == FW, "R3 clock count", f_rises, FW);
    chk(chain == d, "R3 chain contents", chain, d);
    chk(latched == d, "R7 latched contents", latched, d);
    chk(v_setup == 0, "R4 setup violations", v_setup, 0);
    chk(v_high == 0 && v_hold == 0, "R5 high width/hold violations", v_high + v_hold, 0);
    chk(v_low == 0, "R6 low interval violations", v_low, 0);
    if (!byp) begin
      chk(gap == LO + GP, "R7 last fall to strobe", gap, LO + GP);
      chk(swidth == LP, "R7 strobe width", swidth, LP);
    end
    chk(dage == 1, "R8 done delay after strobe fall", dage, 1);
    chk(frame_ready_o == 1'b1, "R8 ready in done cycle", frame_ready_o, 1);
    chk(v_mode == 0 && !blank_o && !strobe_o, "R9 blank/strobe window", v_mode, 0);
    if (next_arm) begin
      frame_i = nd; blank_mode_i = nbyp; frame_valid_i = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(frame_ready_o && !sck_o && !sdo_o && !strobe_o && !blank_o && !done_o,
        "R1 reset state", {frame_ready_o, sck_o, sdo_o, strobe_o, blank_o, done_o}, 6'b100000);
    for (int i = 0; i < FW; i++) run_frame(FW'(1) << i, 1'b0, 1'b0, (i % 4) == 0, 1'b0, '0, 1'b0);
    for (int i = 0; i < FW; i++) run_frame(~(FW'(1) << i), 1'b1, 1'b0, (i % 4) == 1, 1'b0, '0, 1'b0);
    run_frame('0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    run_frame('1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    // Back-to-back chain: each next frame is offered in the done cycle.
    for (int i = 0; i < 12; i++) begin
      logic [FW-1:0] cur, nxt;
      cur = FW'(i * 16'h9E37) ^ 16'h5A5A;
      nxt = FW'((i + 1) * 16'h9E37) ^ 16'h5A5A;
      run_frame(cur, (i % 3) == 1, i > 0, 1'b0, i < 11, nxt, ((i + 1) % 3) == 1);
    end
    repeat (5) @(posedge clk);
    summary();
  end
endmodule